// File: doc/BRIEF.md
# Output Load-Sensing Counter Bank

This block keeps one congestion counter per router output for adaptive routing in a network that has no credit counts. Each counter gives the occupancy of a watched stretch of that output's channel. A routing decision charges the whole packet length to the chosen output at the moment the decision is made. Each flit that leaves the watched stretch takes one away.

In every cycle, each input that is deciding names two candidate outputs and a packet length. The inputs are handled in index order. Input i compares the counter values after the charges of inputs 0 to i-1 from the same cycle, and takes the candidate with the lower value. When several inputs head for the same output, each one sees the load the others have just added. All charges and drains from the cycle go into the registered counters at the next clock edge.

Top module: `load_sense_counters`

## Requirements
- R1: A synchronous active-low reset sets every output counter to zero.
- R2: A request with `req_valid[i]` high adds `req_len[i]` to the counter of the output that input i chose, and the counter shows the new value one clock edge later.
- R3: A high `flit_leave[o]` with no charge to output o lowers its counter by exactly one at the next edge.
- R4: A charge and a drain to the same output in the same cycle are applied together, giving old + length - 1.
- R5: A counter saturates at 2^CNT_W - 1 and never wraps.
- R6: A counter at zero stays at zero when it is drained and not charged.
- R7: Input i picks the candidate whose running count is strictly lower. On a tie it picks candidate A. `sel_second[i]`=1 means candidate B was picked, and `sel_port[i]` gives the index of the picked output.
- R8: Input i's comparison includes the charges of all lower-indexed valid inputs from the same cycle. Higher-indexed inputs and drains are not included.
- R9: A request with `req_valid[i]` low charges nothing, although its selection is still shown.
- R10: Several same-cycle charges to one output add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_IN | One bit per input: a routing decision is made this cycle |
| req_cand_a | input | NUM_IN*IDX_W | First candidate output per input; wins ties |
| req_cand_b | input | NUM_IN*IDX_W | Second candidate output per input |
| req_len | input | NUM_IN*LEN_W | Packet length in flits per input |
| flit_leave | input | NUM_OUT | One flit left the watched stretch of output o |
| sel_port | output | NUM_IN*IDX_W | Output index chosen per input (combinational) |
| sel_second | output | NUM_IN | High when candidate B was chosen |
| load_cnt | output | NUM_OUT*CNT_W | Registered counter per output |

## Verification
The assertions check on every cycle that the picked candidate's running count is never above the other, that a counter at its ceiling does not wrap, that a counter at zero is not drained below zero, that an uncharged drain lowers the count by one, and that the counters are zero when reset is released. Only the bench's scenarios show the actual values: whole-length charges, same-cycle visibility between inputs in index order, sums from several inputs on one output, tie-breaking on non-zero counts, and the fact that a request without valid charges nothing.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int LSC_DEF_INPUTS  = 4;
    localparam int LSC_DEF_OUTPUTS = 4;
    localparam int LSC_DEF_CNT_W   = 6;
    localparam int LSC_DEF_LEN_W   = 4;

    // Width wide enough to hold a full counter plus every input's charge
    // in one cycle, so the running values never wrap before the clamp.
    function automatic int lsc_acc_bits(input int cnt_w, input int len_w, input int n_in);
        return cnt_w + len_w + $clog2(n_in + 1) + 1;
    endfunction

endpackage

// File: rtl/lsc_route_chain.sv
module lsc_route_chain #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 6,
    parameter int LEN_W   = 4,
    parameter int IDX_W   = 2,
    parameter int ACC_W   = 14
) (
    input  logic [NUM_OUT-1:0][CNT_W-1:0] base,
    input  logic [NUM_IN-1:0]             req_valid,
    input  logic [NUM_IN-1:0][IDX_W-1:0]  cand_a,
    input  logic [NUM_IN-1:0][IDX_W-1:0]  cand_b,
    input  logic [NUM_IN-1:0][LEN_W-1:0]  req_len,
    output logic [NUM_OUT-1:0][ACC_W-1:0] total,
    output logic [NUM_OUT-1:0]            charged,
    output logic [NUM_IN-1:0][IDX_W-1:0]  chosen,
    output logic [NUM_IN-1:0]             took_second,
    output logic [NUM_IN-1:0][ACC_W-1:0]  seen_win,
    output logic [NUM_IN-1:0][ACC_W-1:0]  seen_lose
);

    // Inputs are walked in index order; each sees earlier inputs' charges.
    always_comb begin : p_chain
        logic [NUM_OUT-1:0][ACC_W-1:0] run_d;
        logic [ACC_W-1:0]              va_d;
        logic [ACC_W-1:0]              vb_d;
        logic                          pb_d;
        logic [IDX_W-1:0]              pick_d;

        for (int o = 0; o < NUM_OUT; o++) begin
            run_d[o] = ACC_W'(base[o]);
        end
        charged     = '0;
        chosen      = '0;
        took_second = '0;
        seen_win    = '0;
        seen_lose   = '0;

        for (int i = 0; i < NUM_IN; i++) begin
            va_d   = run_d[cand_a[i]];
            vb_d   = run_d[cand_b[i]];
            pb_d   = (vb_d < va_d);
            pick_d = pb_d ? cand_b[i] : cand_a[i];

            chosen[i]      = pick_d;
            took_second[i] = pb_d;
            seen_win[i]    = pb_d ? vb_d : va_d;
            seen_lose[i]   = pb_d ? va_d : vb_d;

            if (req_valid[i]) begin
                run_d[pick_d]   = run_d[pick_d] + ACC_W'(req_len[i]);
                charged[pick_d] = 1'b1;
            end
        end

        total = run_d;
    end

endmodule

// File: rtl/lsc_sat_update.sv
module lsc_sat_update #(
    parameter int CNT_W = 6,
    parameter int ACC_W = 14
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             drain,
    output logic [CNT_W-1:0] nxt
);

    localparam logic [ACC_W-1:0] CAP = {{(ACC_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [ACC_W-1:0] net_d;

    // Drain and charge land together; zero floor first, then the ceiling.
    always_comb begin
        net_d = acc - ACC_W'(drain && (acc != '0));
        nxt   = (net_d > CAP) ? {CNT_W{1'b1}} : net_d[CNT_W-1:0];
    end

endmodule

// File: rtl/load_sense_counters.sv
module load_sense_counters
    import lsc_pkg::*;
#(
    parameter int NUM_IN  = LSC_DEF_INPUTS,
    parameter int NUM_OUT = LSC_DEF_OUTPUTS,
    parameter int CNT_W   = LSC_DEF_CNT_W,
    parameter int LEN_W   = LSC_DEF_LEN_W,
    localparam int IDX_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IN-1:0]          req_valid,
    input  logic [NUM_IN*IDX_W-1:0]    req_cand_a,
    input  logic [NUM_IN*IDX_W-1:0]    req_cand_b,
    input  logic [NUM_IN*LEN_W-1:0]    req_len,
    input  logic [NUM_OUT-1:0]         flit_leave,
    output logic [NUM_IN*IDX_W-1:0]    sel_port,
    output logic [NUM_IN-1:0]          sel_second,
    output logic [NUM_OUT*CNT_W-1:0]   load_cnt
);

    localparam int ACC_W = lsc_acc_bits(CNT_W, LEN_W, NUM_IN);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_OUT-1:0][CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_IN-1:0][IDX_W-1:0]  cand_a_v, cand_b_v, chosen_v;
    logic [NUM_IN-1:0][LEN_W-1:0]  len_v;
    logic [NUM_OUT-1:0][ACC_W-1:0] total_v;
    logic [NUM_OUT-1:0]            charged_v;
    logic [NUM_IN-1:0][ACC_W-1:0]  seen_win_v, seen_lose_v;
    logic [NUM_OUT-1:0][CNT_W-1:0] nxt_v;

    assign cand_a_v = req_cand_a;
    assign cand_b_v = req_cand_b;
    assign len_v    = req_len;

    lsc_route_chain #(
        .NUM_IN (NUM_IN),
        .NUM_OUT(NUM_OUT),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W),
        .ACC_W  (ACC_W)
    ) u_chain (
        .base       (state_q.cnt),
        .req_valid  (req_valid),
        .cand_a     (cand_a_v),
        .cand_b     (cand_b_v),
        .req_len    (len_v),
        .total      (total_v),
        .charged    (charged_v),
        .chosen     (chosen_v),
        .took_second(sel_second),
        .seen_win   (seen_win_v),
        .seen_lose  (seen_lose_v)
    );

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        lsc_sat_update #(
            .CNT_W(CNT_W),
            .ACC_W(ACC_W)
        ) u_sat (
            .acc  (total_v[go]),
            .drain(flit_leave[go]),
            .nxt  (nxt_v[go])
        );

        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.cnt[go] == CNT_MAX && !flit_leave[go]) |=> state_q.cnt[go] == CNT_MAX);

        assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.cnt[go] == '0 && !charged_v[go]) |=> state_q.cnt[go] == '0);

        assert_single_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q.cnt[go] != '0 && !charged_v[go] && flit_leave[go])
            |=> state_q.cnt[go] == CNT_W'($past(state_q.cnt[go]) - 1'b1));

        assert_charge_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (charged_v[go] && !flit_leave[go]) |=> state_q.cnt[go] >= $past(state_q.cnt[go]));
    end

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in_chk
        assert_pick_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
            seen_win_v[gi] <= seen_lose_v[gi]);
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_q.cnt == '0);

    always_comb begin
        state_d = state_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            state_d.cnt[o] = nxt_v[o];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_port = chosen_v;
    assign load_cnt = state_q.cnt;

endmodule

// File: tb/load_sense_counters_bench.sv
module load_sense_counters_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]       vld;
        logic [3:0][1:0]  ca;
        logic [3:0][1:0]  cb;
        logic [3:0][3:0]  len;
        logic [3:0]       leave;
        logic [3:0][1:0]  esel;
        logic [3:0][5:0]  eload;
    } vec_t;

    // Fields listed index 3 down to 0; eload is the count after the edge.
    localparam vec_t VECS [5] = '{
        '{4'b0001, {2'd0,2'd0,2'd0,2'd1}, {2'd0,2'd0,2'd0,2'd2}, {4'd0,4'd0,4'd0,4'd5},
          4'b0000, {2'd0,2'd0,2'd0,2'd1}, {6'd0,6'd0,6'd5,6'd0}},
        '{4'b0111, {2'd0,2'd0,2'd0,2'd0}, {2'd3,2'd3,2'd3,2'd3}, {4'd0,4'd4,4'd2,4'd3},
          4'b0010, {2'd0,2'd3,2'd3,2'd0}, {6'd6,6'd0,6'd4,6'd3}},
        '{4'b0001, {2'd0,2'd0,2'd0,2'd1}, {2'd0,2'd0,2'd0,2'd2}, {4'd0,4'd0,4'd0,4'd7},
          4'b0101, {2'd0,2'd0,2'd0,2'd2}, {6'd6,6'd6,6'd4,6'd2}},
        '{4'b0010, {2'd0,2'd3,2'd3,2'd3}, {2'd0,2'd1,2'd2,2'd1}, {4'd0,4'd0,4'd1,4'd0},
          4'b0000, {2'd0,2'd1,2'd3,2'd1}, {6'd7,6'd6,6'd4,6'd2}},
        '{4'b1111, {2'd2,2'd0,2'd0,2'd0}, {2'd3,2'd1,2'd1,2'd1}, {4'd0,4'd1,4'd1,4'd2},
          4'b1111, {2'd2,2'd1,2'd0,2'd0}, {6'd6,6'd5,6'd4,6'd4}}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      req_valid = '0;
    logic [3:0][1:0] req_cand_a = '0;
    logic [3:0][1:0] req_cand_b = '0;
    logic [3:0][3:0] req_len = '0;
    logic [3:0]      flit_leave = '0;
    logic [7:0]      sel_port;
    logic [3:0]      sel_second;
    logic [23:0]     load_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_sense_counters u_load_sense_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cand_a(req_cand_a),
        .req_cand_b(req_cand_b),
        .req_len   (req_len),
        .flit_leave(flit_leave),
        .sel_port  (sel_port),
        .sel_second(sel_second),
        .load_cnt  (load_cnt)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [3:0][1:0] a, input logic [3:0][1:0] b,
                         input logic [3:0][3:0] l, input logic [3:0] lv);
        @(negedge clk);
        req_valid  = v;
        req_cand_a = a;
        req_cand_b = b;
        req_len    = l;
        flit_leave = lv;
    endtask

    task automatic check_all_loads(input string tag, input logic [3:0][5:0] exp_l);
        for (int o = 0; o < 4; o++) begin
            check(tag, int'(load_cnt[o*6 +: 6]), int'(exp_l[o]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all_loads("R1 reset value", {6'd0,6'd0,6'd0,6'd0});
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R7 R8 R10
        foreach (VECS[k]) begin
            drive(VECS[k].vld, VECS[k].ca, VECS[k].cb, VECS[k].len, VECS[k].leave);
            #1;
            for (int i = 0; i < 4; i++) begin
                check("R7/R8 selected port", int'(sel_port[i*2 +: 2]), int'(VECS[k].esel[i]));
                check("R7 second flag", int'(sel_second[i]),
                      int'(VECS[k].esel[i] != VECS[k].ca[i]));
            end
            @(posedge clk);
            #1;
            check_all_loads("R2/R3/R4/R10 counter", VECS[k].eload);
        end

        // R9: requests without valid charge nothing
        drive(4'b0000, '0, '0, {4'd15,4'd15,4'd15,4'd15}, 4'b0000);
        @(posedge clk);
        #1;
        check_all_loads("R9 no charge", {6'd6,6'd5,6'd4,6'd4});

        // R5: saturation at 63 for output 0 (start 4)
        for (int n = 0; n < 4; n++) begin
            drive(4'b0001, '0, '0, {4'd0,4'd0,4'd0,4'd15}, 4'b0000);
        end
        @(posedge clk);
        #1;
        check("R5 saturated", int'(load_cnt[5:0]), 63);
        drive(4'b0001, '0, '0, {4'd0,4'd0,4'd0,4'd15}, 4'b0001);
        @(posedge clk);
        #1;
        check("R4/R5 charge with drain at ceiling", int'(load_cnt[5:0]), 63);
        drive(4'b0000, '0, '0, '0, 4'b0001);
        @(posedge clk);
        #1;
        check("R3 drain from ceiling", int'(load_cnt[5:0]), 62);

        // R1: reset in mid-run
        @(negedge clk);
        req_valid  = '0;
        flit_leave = '0;
        rst_n      = 1'b0;
        @(posedge clk);
        #1;
        check_all_loads("R1 mid-run reset", {6'd0,6'd0,6'd0,6'd0});
        @(negedge clk);
        rst_n = 1'b1;

        // R6: drains at zero keep zero
        drive(4'b0000, '0, '0, '0, 4'b1111);
        @(posedge clk);
        #1;
        check_all_loads("R6 floor", {6'd0,6'd0,6'd0,6'd0});

        // R7: tie at zero goes to candidate A even when B has lower index
        drive(4'b0001, {2'd0,2'd0,2'd0,2'd3}, {2'd0,2'd0,2'd0,2'd0}, {4'd0,4'd0,4'd0,4'd2}, 4'b0000);
        #1;
        check("R7 tie to A", int'(sel_port[1:0]), 3);
        @(posedge clk);
        #1;
        check_all_loads("R2 charge after tie", {6'd2,6'd0,6'd0,6'd0});

        drive(4'b0000, '0, '0, '0, 4'b0000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule